// File: doc/BRIEF.md
# Cascaded Peripheral Interrupt Aggregator

This block gathers interrupt requests from the five function cells of a multi-function companion device and folds them into a single active-low request line for the host's interrupt controller. Each request input sets a sticky bit in a byte-wide status register. A byte-wide mask register, where a 1 blocks its bit, decides which of those bits may pull the line. Host software reads the status, services the cells and clears bits by writing ones. It keeps doing so until no unmasked bit remains. The line then returns high, so the host sees a fresh falling edge on the next request.

A small byte-addressed register port is provided. It has a write strobe, a read strobe, an address and write data, and it returns read data combinationally while the read strobe is high. The same port also gives access to a read-only revision byte and a plain read/write routing byte. The routing byte is stored only and has no effect on the request line.

Top module: `cell_irq_hub`

## Requirements
- R1: While `rst` is sampled high on a rising edge, status becomes 0x00, mask becomes 0xBF, routing becomes 0x00 and `irq_n` becomes 1.
- R2: A high level on `src_i[k]` at a rising edge sets status bit k at that edge, and the bit stays set after the input falls. The bit positions are fixed: storage cell 0, card slot 1, USB host 2, serial port 3, display 4.
- R3: Status sits at address 0x50 and is write-one-to-clear: writing a byte clears each status bit whose data bit is 1, and data bits of 0 leave status unchanged.
- R4: When a source input is high in the same cycle as a write that clears its status bit, the bit stays set.
- R5: Mask sits at address 0x52 and is read/write. A 1 in a mask bit keeps the matching status bit from affecting `irq_n`.
- R6: `irq_n` is registered. It is 0 in the cycle after the value (status AND NOT mask) is non-zero, and 1 in the cycle after that value is zero.
- R7: Routing sits at address 0x54 and is read/write. Its value has no effect on `irq_n`.
- R8: Address 0x08 reads the revision parameter `REV_ID`, and writes to it are ignored.
- R9: Reads of any other address return 0. Status bits at and above `NUM_SRC` always read 0. `rdata` is 0 whenever `rd_en` is low.
- R10: `rdata` shows the addressed register in the same cycle that `rd_en` is high, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | NUM_SRC | Request inputs from the function cells, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| irq_n | output | 1 | Cascade request to the host, active low |

## Verification
The assertions assume that `rst` is held high for at least one rising edge before any other activity. They also assume that strobes, address, data and source inputs are known values that change only between clock edges. The reset and no-past properties depend on that opening reset cycle. The stimulus keeps to these assumptions by asserting reset for several cycles at the start and by changing every input one time unit after a rising edge. Each strobe is held for exactly one cycle, and the read and write strobes are never raised together.

// File: rtl/cell_irq_hub.sv
module cell_irq_hub #(
  parameter int NUM_SRC = 5,
  parameter int AW = 8,
  parameter logic [7:0] REV_ID = 8'h03,
  parameter logic [7:0] MASK_INIT = 8'hBF,
  parameter logic [AW-1:0] A_REV = 'h08,
  parameter logic [AW-1:0] A_STAT = 'h50,
  parameter logic [AW-1:0] A_MASK = 'h52,
  parameter logic [AW-1:0] A_ROUTE = 'h54
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic               irq_n
);

  logic [7:0] status_q, mask_q, route_q;
  logic [7:0] src_w, clr_w, pend_w;

  assign src_w  = 8'(src_i);
  assign clr_w  = (wr_en && addr == A_STAT) ? wdata : 8'h00;
  assign pend_w = status_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 8'h00;
      mask_q   <= MASK_INIT;
      route_q  <= 8'h00;
      irq_n    <= 1'b1;
    end else begin
      status_q <= (status_q & ~clr_w) | src_w;
      if (wr_en && addr == A_MASK)  mask_q  <= wdata;
      if (wr_en && addr == A_ROUTE) route_q <= wdata;
      irq_n <= ~|pend_w;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      case (addr)
        A_REV:   rdata = REV_ID;
        A_STAT:  rdata = status_q;
        A_MASK:  rdata = mask_q;
        A_ROUTE: rdata = route_q;
        default: rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/cell_irq_hub_chk.sv
module cell_irq_hub_chk #(
  parameter int NUM_SRC = 5,
  parameter int AW = 8,
  parameter logic [7:0] REV_ID = 8'h03,
  parameter logic [7:0] MASK_INIT = 8'hBF,
  parameter logic [AW-1:0] A_REV = 'h08,
  parameter logic [AW-1:0] A_STAT = 'h50,
  parameter logic [AW-1:0] A_MASK = 'h52,
  parameter logic [AW-1:0] A_ROUTE = 'h54
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_i,
  input logic               wr_en,
  input logic               rd_en,
  input logic [AW-1:0]      addr,
  input logic [7:0]         wdata,
  input logic [7:0]         rdata,
  input logic               irq_n,
  input logic [7:0]         status,
  input logic [7:0]         mask
);

  logic [7:0] src_w;
  assign src_w = 8'(src_i);

  AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (status == 8'h00 && mask == MASK_INIT && irq_n)); // R1
  AST_STICKY: assert property (@(posedge clk) disable iff (rst) !(wr_en && addr == A_STAT) |=> ((status & $past(status)) == $past(status))); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) (|src_w) |=> ((status & $past(src_w)) == $past(src_w))); // R4
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst) (wr_en && addr == A_MASK) |=> (mask == $past(wdata))); // R5
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (rst) ((status & ~mask) != 8'h00) |=> !irq_n); // R6
  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (rst) ((status & ~mask) == 8'h00) |=> irq_n); // R6
  AST_REV_READ: assert property (@(posedge clk) disable iff (rst) (rd_en && addr == A_REV) |-> (rdata == REV_ID)); // R8
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst) !rd_en |-> (rdata == 8'h00)); // R9
  AST_HOLE_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != A_REV && addr != A_STAT && addr != A_MASK && addr != A_ROUTE) |-> (rdata == 8'h00)); // R9

endmodule

bind cell_irq_hub cell_irq_hub_chk #(
  .NUM_SRC(NUM_SRC), .AW(AW), .REV_ID(REV_ID), .MASK_INIT(MASK_INIT),
  .A_REV(A_REV), .A_STAT(A_STAT), .A_MASK(A_MASK), .A_ROUTE(A_ROUTE)
) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n),
  .status(status_q), .mask(mask_q)
);

// File: tb/sim_cell_irq_hub.sv
`timescale 1ns/1ps
module sim_cell_irq_hub;
  localparam logic [7:0] REV = 8'h03;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] src_i = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  cell_irq_hub u0 (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  // monitor: pops one expected item for every read strobe
  always @(negedge clk) begin
    if (rd_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: read with no expected item, got %02h", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s: rdata=%02h expected=%02h", t, rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] v);
    @(posedge clk); #1;
    src_i = v;
    @(posedge clk); #1;
    src_i = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(posedge clk); #1;
    checks++;
    if (irq_n !== e) begin
      failures++;
      $display("FAIL %s: irq_n=%0b expected=%0b", t, irq_n, e);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset values
    chk_irq(1'b1, "R1");
    rd(8'h50, 8'h00, "R1");
    rd(8'h52, 8'hBF, "R1");
    rd(8'h54, 8'h00, "R1");
    rd(8'h08, REV, "R8");

    // R5 default mask blocks the storage cell source
    pulse(5'b00001);
    chk_irq(1'b1, "R5");
    rd(8'h50, 8'h01, "R2");
    repeat (3) @(posedge clk);
    rd(8'h50, 8'h01, "R2");

    // R6 unmasking raises the request
    wr(8'h52, 8'hFE);
    chk_irq(1'b0, "R6");
    wr(8'h50, 8'h00);
    rd(8'h50, 8'h01, "R3");
    chk_irq(1'b0, "R3");
    wr(8'h50, 8'h01);
    chk_irq(1'b1, "R6");
    rd(8'h50, 8'h00, "R3");

    // R2 each fixed position
    wr(8'h52, 8'hE0);
    rd(8'h52, 8'hE0, "R5");
    for (int i = 0; i < 5; i++) begin
      pulse(5'(1 << i));
      rd(8'h50, 8'(1 << i), "R2");
      chk_irq(1'b0, "R6");
      wr(8'h50, 8'(1 << i));
      chk_irq(1'b1, "R6");
    end

    // R3 partial clear of two sources
    pulse(5'b10100);
    rd(8'h50, 8'h14, "R2");
    wr(8'h50, 8'h04);
    rd(8'h50, 8'h10, "R3");
    chk_irq(1'b0, "R6");
    wr(8'h50, 8'h10);
    chk_irq(1'b1, "R6");

    // R4 set beats clear in the same cycle
    @(posedge clk); #1;
    src_i = 5'b01000;
    @(posedge clk); #1;
    wr_en = 1'b1; addr = 8'h50; wdata = 8'h08;
    @(posedge clk); #1;
    wr_en = 1'b0; src_i = '0;
    rd(8'h50, 8'h08, "R4");
    chk_irq(1'b0, "R4");
    wr(8'h50, 8'h08);
    chk_irq(1'b1, "R3");

    // R7 routing stored, no effect on the line; R5 masking a pending bit
    wr(8'h54, 8'hA5);
    rd(8'h54, 8'hA5, "R7");
    pulse(5'b00010);
    chk_irq(1'b0, "R6");
    wr(8'h54, 8'h00);
    chk_irq(1'b0, "R7");
    wr(8'h54, 8'hFF);
    chk_irq(1'b0, "R7");
    wr(8'h52, 8'hFF);
    chk_irq(1'b1, "R5");
    wr(8'h52, 8'hE0);
    chk_irq(1'b0, "R5");
    wr(8'h50, 8'h02);
    chk_irq(1'b1, "R6");

    // R8 revision is read only
    wr(8'h08, 8'hFF);
    rd(8'h08, REV, "R8");

    // R9 holes, spare bits and idle read; R10 same-cycle data
    rd(8'h51, 8'h00, "R9");
    rd(8'h00, 8'h00, "R9");
    rd(8'hFF, 8'h00, "R9");
    rd(8'h53, 8'h00, "R9");
    pulse(5'b11111);
    wr(8'h52, 8'h00);
    rd(8'h50, 8'h1F, "R9");
    rd(8'h52, 8'h00, "R10");
    wr(8'h50, 8'hFF);
    rd(8'h50, 8'h00, "R3");
    @(negedge clk);
    checks++;
    if (rdata !== 8'h00) begin
      failures++;
      $display("FAIL R9: idle rdata=%02h expected=00", rdata);
    end

    repeat (2) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule